// File: doc/BRIEF.md
# Key-locked system control register bank

This block is a bank of 32-bit control registers on a simple register port with valid, write, byte address and data. Every access is a single aligned 32-bit word. The word index is the byte address divided by four. The decoded window is 4 KiB. Only the lowest `NUM_REGS` words hold storage.

Most of the lower part of the map is write-protected. A key register at offset 0x00 acts as an unlock flag. Writing the magic key to it sets the flag, and writing any other value clears it. While the flag is clear, writes to offsets 0x04 through 0x100 are discarded.

The bank also has three kinds of special word:
- A strap word at 0x70. It is set and cleared through two addresses, and which behaviour applies depends on a silicon-variant input.
- A revision word at 0x7C and eight scratch words at 0x50–0x6C. None of these can be changed by writes.
- A random word at 0x78. Every read returns the next value of a linear feedback shift register.

Reset loads fixed defaults into the bank. The key, revision and both strap words are instead loaded from input ports at reset.

Top module: `sysctl_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every word resets to zero except these:
  - 0x04 = 0xFFCFFEDC, 0x3C = 0x00000001, 0x40 = 0x000000C0, 0x74 = 0x0000000E and 0x1A4 = 0x00002402.
  - 0x00, 0x70, 0xD0 and 0x7C take `key_init`, `strap_lo_init`, `strap_hi_init` and `rev_init`.
  - The random generator returns to `RNG_SEED`.
  - A nonzero `key_init` leaves the bank unlocked.
- R2: `rsp_rdata` carries the read word in the cycle after the read request. It is zero in every cycle that does not follow a read request.
- R3: A write to 0x00 is always accepted. It stores 1 if the data equals `UNLOCK_KEY` (default 0x5A17C0DE) and 0 otherwise. The bank is unlocked whenever the word at 0x00 is nonzero.
- R4: While the bank is locked, a write to any offset from 0x04 to 0x100 inclusive is discarded. Offsets 0x104 and above remain writable while locked.
- R5: With `variant_new` = 1, a write to 0x70 ORs the data into the strap word. With `variant_new` = 0, it replaces the strap word.
- R6: With `variant_new` = 1, a write to 0x7C clears the strap-word bits that are set in the data. With `variant_new` = 0, a write to 0x7C is discarded. The word at 0x7C never changes after reset.
- R7: Writes to the scratch words at 0x50 to 0x6C are discarded.
- R8: Each read of 0x78 returns the generator state and then advances it with next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. The value of the control word at 0x74 has no effect on this. Writes to 0x78 are discarded.
- R9: These accesses are ignored: any access with address bits [1:0] nonzero, and any access at word index `NUM_REGS` (default 106, offset 0x1A8) or above. Such a write is discarded, and such a read returns zero without advancing the generator.
- R10: `rsp_wr_reject` is high for exactly the cycle after a write discarded under R4, R6, R7, R8 or R9. It is low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| variant_new | input | 1 | 1 selects set/clear strap behaviour, 0 the plain one |
| key_init | input | 32 | Reset value of the key word |
| strap_lo_init | input | 32 | Reset value of the strap word at 0x70 |
| strap_hi_init | input | 32 | Reset value of the strap word at 0xD0 |
| rev_init | input | 32 | Reset value of the revision word |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the read |
| rsp_wr_reject | output | 1 | Pulse one cycle after a discarded write |

## Verification
Each result of the bank comes out exactly one clock after its request:
- read data, the reject pulse and the random word each appear in the cycle after the request;
- a stored write becomes visible to a read issued in the cycle after it.

The bench drives requests on the falling edge. A behavioural model updates its expected read word and reject flag on each rising edge. The model's expectations and the outputs are then compared at the next falling edge, in every cycle including idle ones.

Directed reads and writes sample the same falling edge, so any extra or missing cycle of latency shows up as a mismatch.

// File: rtl/sysctl_pkg.sv
// Shared constants, write-operation type and reset defaults for the
// key-locked system control register bank. Word indices are byte offsets / 4.
package sysctl_pkg;

    localparam int WORD_W       = 32;
    localparam int IDX_KEY      = 0;    // 0x00 unlock flag
    localparam int IDX_SCR_LO   = 20;   // 0x50 first scratch word
    localparam int IDX_SCR_HI   = 27;   // 0x6C last scratch word
    localparam int IDX_STRAP    = 28;   // 0x70 strap word (set/clear)
    localparam int IDX_RNG      = 30;   // 0x78 random word
    localparam int IDX_REV      = 31;   // 0x7C revision word
    localparam int IDX_STRAP2   = 52;   // 0xD0 second strap word
    localparam int IDX_LOCK_END = 65;   // 0x104 first word writable while locked

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STORE,
        OP_KEY,
        OP_OR,
        OP_CLR
    } wr_op_e;

    // Fixed reset value of a word (port-loaded words are overridden later)
    function automatic logic [WORD_W-1:0] reset_default(input int idx);
        case (idx)
            1:       return 32'hFFCF_FEDC;
            15:      return 32'h0000_0001;
            16:      return 32'h0000_00C0;
            29:      return 32'h0000_000E;
            105:     return 32'h0000_2402;
            default: return '0;
        endcase
    endfunction

    // One step of the 32-bit maximal-length shift register (taps 32,22,2,1)
    function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
        return {s[WORD_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
// Address and write-policy decoder.
// Classifies one request into a read target and a write operation, applying
// alignment, range, key lock, read-only words and the variant-dependent strap
// behaviour. Purely combinational; assumes one request per cycle.
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 106,
    parameter int IDX_W    = 7
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              unlocked,
    input  logic              variant_new,
    output logic              rd_hit,
    output logic              rd_rng,
    output logic [IDX_W-1:0]  rd_idx,
    output wr_op_e            wr_op,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_reject
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    logic              aligned;
    logic              in_range;
    logic              is_scratch;

    // Split address into word index and qualifiers
    always_comb begin
        word_idx   = req_addr[ADDR_W-1:2];
        aligned    = (req_addr[1:0] == 2'b00);
        in_range   = (word_idx < WIDX_W'(NUM_REGS));
        is_scratch = (word_idx >= WIDX_W'(IDX_SCR_LO)) && (word_idx <= WIDX_W'(IDX_SCR_HI));
    end

    // Read target selection
    always_comb begin
        rd_idx = word_idx[IDX_W-1:0];
        rd_rng = req_valid && !req_write && aligned && (word_idx == WIDX_W'(IDX_RNG));
        rd_hit = req_valid && !req_write && aligned && in_range && !rd_rng;
    end

    // Write policy: priority order matters (key, lock, read-only, special)
    always_comb begin
        wr_op     = OP_NONE;
        wr_idx    = word_idx[IDX_W-1:0];
        wr_reject = 1'b0;
        if (req_valid && req_write) begin
            if (!aligned || !in_range) begin
                wr_reject = 1'b1;
            end else if (word_idx == WIDX_W'(IDX_KEY)) begin
                wr_op = OP_KEY;
            end else if (!unlocked && (word_idx < WIDX_W'(IDX_LOCK_END))) begin
                wr_reject = 1'b1;
            end else if (is_scratch || (word_idx == WIDX_W'(IDX_RNG))) begin
                wr_reject = 1'b1;
            end else if (word_idx == WIDX_W'(IDX_STRAP)) begin
                wr_op = variant_new ? OP_OR : OP_STORE;
            end else if (word_idx == WIDX_W'(IDX_REV)) begin
                if (variant_new) begin
                    wr_op  = OP_CLR;
                    wr_idx = IDX_W'(IDX_STRAP);
                end else begin
                    wr_reject = 1'b1;
                end
            end else begin
                wr_op = OP_STORE;
            end
        end
    end

endmodule

// File: rtl/sysctl_lfsr.sv
// Placeholder random source: a 32-bit maximal-length shift register that
// advances once per accepted random-word read. Assumes SEED is nonzero.
module sysctl_lfsr
    import sysctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] SEED = 32'hACE1_2024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [WORD_W-1:0] state
);
    // Hold or step the generator state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (advance) begin
            state <= lfsr_step(state);
        end
    end

endmodule

// File: rtl/sysctl_reg_store.sv
// Register storage for the bank. Applies the decoded write operation to one
// word per cycle and provides a combinational read port and the unlock flag.
// Assumes the reset-loaded indices lie below NUM_REGS.
module sysctl_reg_store
    import sysctl_pkg::*;
#(
    parameter int                NUM_REGS   = 106,
    parameter int                IDX_W      = 7,
    parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h5A17_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] key_init,
    input  logic [WORD_W-1:0] strap_lo_init,
    input  logic [WORD_W-1:0] strap_hi_init,
    input  logic [WORD_W-1:0] rev_init,
    input  wr_op_e            wr_op,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              unlocked
);
    logic [WORD_W-1:0] regs [NUM_REGS];
    logic [WORD_W-1:0] wr_cur;
    logic [WORD_W-1:0] wr_next;

    // Current value of the write target and its updated value
    always_comb begin
        wr_cur = (int'(wr_idx) < NUM_REGS) ? regs[wr_idx] : '0;
        case (wr_op)
            OP_KEY:  wr_next = (wr_data == UNLOCK_KEY) ? 32'd1 : 32'd0;
            OP_OR:   wr_next = wr_cur | wr_data;
            OP_CLR:  wr_next = wr_cur & ~wr_data;
            default: wr_next = wr_data;
        endcase
    end

    // Reset load and single-word update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= reset_default(i);
            end
            regs[IDX_KEY]    <= key_init;
            regs[IDX_STRAP]  <= strap_lo_init;
            regs[IDX_STRAP2] <= strap_hi_init;
            regs[IDX_REV]    <= rev_init;
        end else if (wr_op != OP_NONE && int'(wr_idx) < NUM_REGS) begin
            regs[wr_idx] <= wr_next;
        end
    end

    // Read port and unlock flag
    always_comb begin
        rd_data  = (int'(rd_idx) < NUM_REGS) ? regs[rd_idx] : '0;
        unlocked = |regs[IDX_KEY];
    end

endmodule

// File: rtl/sysctl_regbank.sv
// Top of the key-locked system control register bank.
// Joins decoder, storage and random source, and registers the response:
// read data and the write-reject pulse appear one cycle after the request.
// Assumes word-wide accesses and a NUM_REGS no larger than the 4 KiB window.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                NUM_REGS   = 106,
    parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h5A17_C0DE,
    parameter logic [WORD_W-1:0] RNG_SEED   = 32'hACE1_2024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_new,
    input  logic [WORD_W-1:0] key_init,
    input  logic [WORD_W-1:0] strap_lo_init,
    input  logic [WORD_W-1:0] strap_hi_init,
    input  logic [WORD_W-1:0] rev_init,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_wr_reject
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic              rd_hit;
    logic              rd_rng;
    logic [IDX_W-1:0]  rd_idx;
    wr_op_e            wr_op;
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_reject;
    logic              unlocked;
    logic [WORD_W-1:0] store_rd;
    logic [WORD_W-1:0] rng_word;

    sysctl_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .unlocked    (unlocked),
        .variant_new (variant_new),
        .rd_hit      (rd_hit),
        .rd_rng      (rd_rng),
        .rd_idx      (rd_idx),
        .wr_op       (wr_op),
        .wr_idx      (wr_idx),
        .wr_reject   (wr_reject)
    );

    sysctl_reg_store #(
        .NUM_REGS   (NUM_REGS),
        .IDX_W      (IDX_W),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .key_init      (key_init),
        .strap_lo_init (strap_lo_init),
        .strap_hi_init (strap_hi_init),
        .rev_init      (rev_init),
        .wr_op         (wr_op),
        .wr_idx        (wr_idx),
        .wr_data       (req_wdata),
        .rd_idx        (rd_idx),
        .rd_data       (store_rd),
        .unlocked      (unlocked)
    );

    sysctl_lfsr #(
        .SEED (RNG_SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rd_rng),
        .state   (rng_word)
    );

    // Registered response: read word or zero, and reject pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata     <= '0;
            rsp_wr_reject <= 1'b0;
        end else begin
            rsp_rdata     <= rd_rng ? rng_word : (rd_hit ? store_rd : '0);
            rsp_wr_reject <= wr_reject;
        end
    end

endmodule

// File: rtl/sysctl_regbank_chk.sv
// Assertion checker for sysctl_regbank, bound to every instance of the top.
// Relates request ports to the response and to the unlock state one cycle on.
module sysctl_regbank_chk #(
    parameter int          ADDR_W     = 12,
    parameter logic [31:0] UNLOCK_KEY = 32'h5A17_C0DE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              variant_new,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_wr_reject,
    input logic              unlocked
);
    logic wr_now;
    logic aligned_now;

    // Request qualifiers shared by the properties
    always_comb begin
        wr_now      = req_valid && req_write;
        aligned_now = (req_addr[1:0] == 2'b00);
    end

    AST_KEY_MATCH_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && req_addr == '0 && req_wdata == UNLOCK_KEY) |=> unlocked); // R3
    AST_KEY_MISMATCH_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && req_addr == '0 && req_wdata != UNLOCK_KEY) |=> !unlocked); // R3
    AST_LOCKED_WINDOW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && !unlocked && aligned_now && req_addr >= ADDR_W'(4) && req_addr < ADDR_W'(12'h104)) |=> rsp_wr_reject); // R4
    AST_OLD_REV_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && !variant_new && req_addr == ADDR_W'(12'h07C)) |=> rsp_wr_reject); // R6
    AST_SCRATCH_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && aligned_now && req_addr >= ADDR_W'(12'h050) && req_addr <= ADDR_W'(12'h06C)) |=> rsp_wr_reject); // R7
    AST_MISALIGNED_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && !aligned_now) |=> rsp_wr_reject); // R9
    AST_RDATA_ZERO_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (rsp_rdata == '0)); // R2
    AST_REJECT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_now |=> !rsp_wr_reject); // R10

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .ADDR_W     (ADDR_W),
    .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .variant_new   (variant_new),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_rdata     (rsp_rdata),
    .rsp_wr_reject (rsp_wr_reject),
    .unlocked      (unlocked)
);

// File: tb/sysctl_regbank_tb.sv
// Self-checking bench: behavioural model compared on every falling edge,
// plus directed reads/writes with hand-computed expectations.
module sysctl_regbank_tb;
    localparam logic [31:0] KEY  = 32'h5A17_C0DE;
    localparam logic [31:0] SEED = 32'hACE1_2024;
    localparam int          NREG = 106;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_new = 1'b1;
    logic [31:0] key_init = '0;
    logic [31:0] strap_lo_init = 32'h0000_0F00;
    logic [31:0] strap_hi_init = 32'h1234_0000;
    logic [31:0] rev_init = 32'h0402_0303;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_wr_reject;

    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;
    string cur_tag = "R1";
    logic [31:0] nrand;

    always #5 clk = ~clk;

    sysctl_regbank u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .variant_new   (variant_new),
        .key_init      (key_init),
        .strap_lo_init (strap_lo_init),
        .strap_hi_init (strap_hi_init),
        .rev_init      (rev_init),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_rdata     (rsp_rdata),
        .rsp_wr_reject (rsp_wr_reject)
    );

    function automatic logic [31:0] rnd_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // ---------------- behavioural model ----------------
    logic [31:0] m [NREG];
    logic [31:0] mrng;
    logic [31:0] exp_rd;
    logic        exp_rej;
    bit          live = 0;
    int          mw;
    bit          mok;

    always @(posedge clk) begin
        live = 1;
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) m[i] = '0;
            m[1] = 32'hFFCF_FEDC; m[15] = 32'h1; m[16] = 32'hC0;
            m[29] = 32'hE; m[105] = 32'h2402;
            m[0] = key_init; m[28] = strap_lo_init; m[52] = strap_hi_init; m[31] = rev_init;
            mrng = SEED; exp_rd = '0; exp_rej = 1'b0;
        end else begin
            exp_rd = '0; exp_rej = 1'b0;
            mw  = int'(req_addr) / 4;
            mok = (req_addr[1:0] == 2'b00) && (mw < NREG);
            if (req_valid && !req_write) begin
                if (mok && mw == 30) begin
                    exp_rd = mrng; mrng = rnd_next(mrng);
                end else if (mok) begin
                    exp_rd = m[mw];
                end
            end else if (req_valid) begin
                if (!mok) exp_rej = 1'b1;
                else if (mw == 0) m[0] = (req_wdata == KEY) ? 32'd1 : 32'd0;
                else if (m[0] == 0 && mw < 65) exp_rej = 1'b1;
                else if ((mw >= 20 && mw <= 27) || mw == 30) exp_rej = 1'b1;
                else if (mw == 28) m[28] = variant_new ? (m[28] | req_wdata) : req_wdata;
                else if (mw == 31) begin
                    if (variant_new) m[28] = m[28] & ~req_wdata;
                    else exp_rej = 1'b1;
                end else m[mw] = req_wdata;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (live && !finished) begin
            compared++;
            if (rsp_rdata !== exp_rd || rsp_wr_reject !== exp_rej) begin
                mismatched++;
                $display("FAIL %s (model): rdata=%h rej=%b expected rdata=%h rej=%b",
                         cur_tag, rsp_rdata, rsp_wr_reject, exp_rd, exp_rej);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        cur_tag = tag; req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_rdata, e, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic erej, input string tag);
        @(negedge clk);
        cur_tag = tag; req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({31'd0, rsp_wr_reject}, {31'd0, erej}, tag);
    endtask

    task automatic rd_rand(input string tag);
        rd(12'h078, nrand, tag);
        nrand = rnd_next(nrand);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nrand = SEED;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    // ---------------- stimulus ----------------
    initial begin
        do_reset();
        // R1 reset state
        check(rsp_rdata, 32'h0, "R1");
        rd(12'h004, 32'hFFCF_FEDC, "R1");
        rd(12'h03C, 32'h0000_0001, "R1");
        rd(12'h040, 32'h0000_00C0, "R1");
        rd(12'h074, 32'h0000_000E, "R1");
        rd(12'h1A4, 32'h0000_2402, "R1");
        rd(12'h070, 32'h0000_0F00, "R1");
        rd(12'h0D0, 32'h1234_0000, "R1");
        rd(12'h07C, 32'h0402_0303, "R1");
        rd(12'h000, 32'h0, "R1");
        rd(12'h008, 32'h0, "R1");
        // R4 locked window, R10 reject pulse
        wr(12'h008, 32'hDEAD, 1'b1, "R4");
        rd(12'h008, 32'h0, "R4");
        wr(12'h104, 32'h1111, 1'b0, "R4");
        rd(12'h104, 32'h1111, "R4");
        wr(12'h070, 32'hFF, 1'b1, "R10");
        rd(12'h070, 32'h0000_0F00, "R4");
        // R3 key
        wr(12'h000, 32'h1234_5678, 1'b0, "R3");
        rd(12'h000, 32'h0, "R3");
        wr(12'h000, KEY, 1'b0, "R3");
        rd(12'h000, 32'h1, "R3");
        wr(12'h008, 32'hCAFE, 1'b0, "R4");
        rd(12'h008, 32'hCAFE, "R4");
        wr(12'h100, 32'hABCD, 1'b0, "R4");
        rd(12'h100, 32'hABCD, "R4");
        // R7 scratch
        wr(12'h050, 32'hFFFF, 1'b1, "R7");
        wr(12'h06C, 32'h1, 1'b1, "R7");
        rd(12'h050, 32'h0, "R7");
        rd(12'h06C, 32'h0, "R7");
        // R5 / R6 newer variant
        wr(12'h070, 32'h0000_00F0, 1'b0, "R5");
        rd(12'h070, 32'h0000_0FF0, "R5");
        wr(12'h07C, 32'h0000_0F00, 1'b0, "R6");
        rd(12'h070, 32'h0000_00F0, "R6");
        rd(12'h07C, 32'h0402_0303, "R6");
        // R8 random word
        rd_rand("R8");
        rd_rand("R8");
        wr(12'h074, 32'h0, 1'b0, "R8");
        rd(12'h074, 32'h0, "R8");
        rd_rand("R8");
        wr(12'h078, 32'h5, 1'b1, "R8");
        // R9 range and alignment
        rd(12'h1A8, 32'h0, "R9");
        wr(12'h1A8, 32'h1, 1'b1, "R9");
        rd(12'hFFC, 32'h0, "R9");
        wr(12'h00A, 32'h1, 1'b1, "R9");
        rd(12'h00A, 32'h0, "R9");
        rd(12'h079, 32'h0, "R9");
        rd_rand("R9");
        // Older variant
        variant_new = 1'b0;
        wr(12'h070, 32'h1, 1'b0, "R5");
        rd(12'h070, 32'h1, "R5");
        wr(12'h07C, 32'h1, 1'b1, "R6");
        rd(12'h070, 32'h1, "R6");
        rd(12'h07C, 32'h0402_0303, "R6");
        // Relock and boundary
        wr(12'h000, 32'h0, 1'b0, "R3");
        wr(12'h100, 32'h7, 1'b1, "R4");
        rd(12'h100, 32'hABCD, "R4");
        wr(12'h104, 32'h2, 1'b0, "R4");
        rd(12'h104, 32'h2, "R4");
        // Second reset with a nonzero key from the port
        key_init = 32'h8000_0000;
        do_reset();
        rd(12'h000, 32'h8000_0000, "R1");
        wr(12'h008, 32'hBEEF, 1'b0, "R1");
        rd(12'h008, 32'hBEEF, "R1");
        rd(12'h104, 32'h0, "R1");
        rd_rand("R1");
        repeat (2) @(negedge clk);
        report();
    end

endmodule